// File: doc/BRIEF.md
# Interrupt Moderation Delay Timers

This block holds four countdown timers that moderate interrupts for a network controller. Two belong to the receive side and two to the transmit side. On each side a packet timer starts again from its full delay on every qualifying event. An absolute timer starts on the first event and then runs to its end, which caps the total wait. Each timer counts down one step per pulse of an externally generated time-unit strobe. When a timer reaches its end, the block raises a single-cycle cause pulse for its side.

The receive side is armed by a "packet written" event. When both receive delays are zero, the receive cause is raised at once. The transmit side is armed by a "descriptor completed" event, but only if that descriptor asks for delayed interrupts. An interrupt controller that has just posted an interrupt can clear all pending timers with a single cancel strobe.

Top module: `irq_delay_timers`

## Requirements
- R1: On `rx_pkt_done`, a nonzero `rx_pkt_dly` reloads the receive packet timer with that value. This restarts the timer even if it is already running.
- R2: On `rx_pkt_done`, a nonzero `rx_abs_dly` starts the receive absolute timer only if that timer is idle. A running absolute timer keeps its count.
- R3: If `rx_pkt_done` arrives while both receive delays are zero, `rx_cause` is high for one cycle in the cycle after the event.
- R4: A `tx_desc_done` event with `tx_desc_ide` low does not change either transmit timer.
- R5: On `tx_desc_done` with `tx_desc_ide` high, a nonzero `tx_pkt_dly` reloads the transmit packet timer.
- R6: The transmit absolute timer starts only on `tx_desc_done` with `tx_desc_ide` high, with both transmit delays nonzero, and only if the timer is idle.
- R7: A loaded timer counts only on cycles where `unit_tick` is high. A timer loaded with D expires on the D-th tick. In the cycle after that tick, the cause for its side is high (`rx_cause` for the receive timers, `tx_cause` for the transmit timers) and its running flag is low. `tmr_running` bit 0 is receive packet, bit 1 is receive absolute, bit 2 is transmit packet and bit 3 is transmit absolute.
- R8: `cancel_all` clears all four running flags in the next cycle. It takes priority over arming events, and no timer cause results from the cancel.
- R9: If a reload of a packet timer falls in the same cycle as that timer's final tick, the reload wins. No cause is raised and the timer restarts from the full delay.
- R10: Two timers of one side that expire on the same tick produce a single one-cycle cause pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pkt_done | input | 1 | One-cycle strobe: a received packet was written |
| tx_desc_done | input | 1 | One-cycle strobe: a transmit descriptor completed |
| tx_desc_ide | input | 1 | Delayed-interrupt request flag of the completed descriptor |
| rx_pkt_dly | input | DLY_W | Receive packet delay in time units |
| rx_abs_dly | input | DLY_W | Receive absolute delay in time units |
| tx_pkt_dly | input | DLY_W | Transmit packet delay in time units |
| tx_abs_dly | input | DLY_W | Transmit absolute delay in time units |
| unit_tick | input | 1 | One-cycle time-unit strobe |
| cancel_all | input | 1 | Stops all timers without raising causes |
| rx_cause | output | 1 | Receive timer cause pulse |
| tx_cause | output | 1 | Transmit done cause pulse |
| tmr_running | output | 4 | Running flags, one per timer |

## Verification
The bench builds the block with `DLY_W` set to 8. This makes the largest delay of 255 ticks reachable within a short run, so the full-range count and the all-ones load value are exercised together with small delays. A continuous tick lets the table measure expiry times exactly, including equal and unequal pairs of delays on one side. Directed cases cover restart versus hold, gaps in the tick strobe, a reload that meets the final tick, and cancel.

// File: rtl/irq_dly_pkg.sv
package irq_dly_pkg;
  localparam int NUM_TMR = 4;

  typedef enum int {
    TMR_RX_PKT = 0,
    TMR_RX_ABS = 1,
    TMR_TX_PKT = 2,
    TMR_TX_ABS = 3
  } tmr_idx_e;

  function automatic bit tmr_restarts(input int idx);
    return (idx == TMR_RX_PKT) || (idx == TMR_TX_PKT);
  endfunction

  function automatic bit tmr_is_rx(input int idx);
    return (idx == TMR_RX_PKT) || (idx == TMR_RX_ABS);
  endfunction
endpackage

// File: rtl/dly_arm_decode.sv
module dly_arm_decode
  import irq_dly_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic                            rx_pkt_done,
  input  logic                            tx_desc_done,
  input  logic                            tx_desc_ide,
  input  logic [NUM_TMR-1:0][DLY_W-1:0]   dly_vec,
  output logic [NUM_TMR-1:0]              arm,
  output logic                            rx_now
);
  logic [NUM_TMR-1:0] nz;

  always_comb begin
    for (int i = 0; i < NUM_TMR; i++) nz[i] = |dly_vec[i];
  end

  logic tx_ok;
  assign tx_ok = tx_desc_done && tx_desc_ide;

  always_comb begin
    arm[TMR_RX_PKT] = rx_pkt_done && nz[TMR_RX_PKT];
    arm[TMR_RX_ABS] = rx_pkt_done && nz[TMR_RX_ABS];
    arm[TMR_TX_PKT] = tx_ok && nz[TMR_TX_PKT];
    arm[TMR_TX_ABS] = tx_ok && nz[TMR_TX_PKT] && nz[TMR_TX_ABS];
    rx_now          = rx_pkt_done && !nz[TMR_RX_PKT] && !nz[TMR_RX_ABS];
  end
endmodule

// File: rtl/dly_timer.sv
module dly_timer #(
  parameter int DLY_W   = 16,
  parameter bit RESTART = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DLY_W-1:0] dly,
  input  logic             arm,
  input  logic             tick,
  input  logic             cancel,
  output logic             running,
  output logic             expire
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt;
  logic             load;

  always_comb begin
    load   = arm && !cancel && (RESTART || !running);
    expire = running && tick && (cnt == ONE) && !cancel && !load;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (cancel) begin
      running <= 1'b0;
    end else if (load) begin
      running <= 1'b1;
      cnt     <= dly;
    end else if (running && tick) begin
      if (cnt == ONE) running <= 1'b0;
      cnt <= cnt - ONE;
    end
  end

  generate
    if (RESTART) begin : g_restart_chk
      AST_PKT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        arm && !cancel |=> running && cnt == $past(dly)); // R1
    end else begin : g_hold_chk
      AST_ABS_HOLD: assert property (@(posedge clk) disable iff (rst)
        running && !tick && !cancel |=> running && $stable(cnt)); // R2
    end
  endgenerate
endmodule

// File: rtl/irq_delay_timers.sv
module irq_delay_timers
  import irq_dly_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_pkt_done,
  input  logic             tx_desc_done,
  input  logic             tx_desc_ide,
  input  logic [DLY_W-1:0] rx_pkt_dly,
  input  logic [DLY_W-1:0] rx_abs_dly,
  input  logic [DLY_W-1:0] tx_pkt_dly,
  input  logic [DLY_W-1:0] tx_abs_dly,
  input  logic             unit_tick,
  input  logic             cancel_all,
  output logic             rx_cause,
  output logic             tx_cause,
  output logic [3:0]       tmr_running
);
  logic [NUM_TMR-1:0][DLY_W-1:0] dly_vec;
  logic [NUM_TMR-1:0]            arm;
  logic [NUM_TMR-1:0]            expire;
  logic [NUM_TMR-1:0]            run_vec;
  logic                          rx_now;

  assign dly_vec[TMR_RX_PKT] = rx_pkt_dly;
  assign dly_vec[TMR_RX_ABS] = rx_abs_dly;
  assign dly_vec[TMR_TX_PKT] = tx_pkt_dly;
  assign dly_vec[TMR_TX_ABS] = tx_abs_dly;

  dly_arm_decode #(.DLY_W(DLY_W)) u_arm (
    .rx_pkt_done (rx_pkt_done),
    .tx_desc_done(tx_desc_done),
    .tx_desc_ide (tx_desc_ide),
    .dly_vec     (dly_vec),
    .arm         (arm),
    .rx_now      (rx_now)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
      dly_timer #(.DLY_W(DLY_W), .RESTART(tmr_restarts(gi))) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .dly    (dly_vec[gi]),
        .arm    (arm[gi]),
        .tick   (unit_tick),
        .cancel (cancel_all),
        .running(run_vec[gi]),
        .expire (expire[gi])
      );
    end
  endgenerate

  logic rx_exp_any, tx_exp_any;
  always_comb begin
    rx_exp_any = 1'b0;
    tx_exp_any = 1'b0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (tmr_is_rx(i)) rx_exp_any = rx_exp_any | expire[i];
      else              tx_exp_any = tx_exp_any | expire[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cause <= 1'b0;
      tx_cause <= 1'b0;
    end else begin
      rx_cause <= rx_exp_any | rx_now;
      tx_cause <= tx_exp_any;
    end
  end

  assign tmr_running = run_vec;

  AST_RX_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    rx_pkt_done && rx_pkt_dly == '0 && rx_abs_dly == '0 |=> rx_cause); // R3
  AST_TX_IDE_GATE: assert property (@(posedge clk) disable iff (rst)
    tx_desc_done && !tx_desc_ide && !tmr_running[2] |=> !tmr_running[2]); // R4
  AST_CANCEL_ALL: assert property (@(posedge clk) disable iff (rst)
    cancel_all |=> tmr_running == 4'b0000 && !tx_cause); // R8
  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
    !unit_tick && !cancel_all && !rx_pkt_done && !tx_desc_done
    |=> tmr_running == $past(tmr_running) && !tx_cause); // R7
endmodule

// File: tb/irq_delay_timers_tb.sv
module irq_delay_timers_tb;
  localparam int W = 8;
  localparam int WIN = 270;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_pkt_done = 0, tx_desc_done = 0, tx_desc_ide = 0;
  logic [W-1:0] rx_pkt_dly = 0, rx_abs_dly = 0, tx_pkt_dly = 0, tx_abs_dly = 0;
  logic unit_tick = 0, cancel_all = 0;
  logic rx_cause, tx_cause;
  logic [3:0] tmr_running;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_delay_timers #(.DLY_W(W)) u_dut (
    .clk(clk), .rst(rst), .rx_pkt_done(rx_pkt_done), .tx_desc_done(tx_desc_done),
    .tx_desc_ide(tx_desc_ide), .rx_pkt_dly(rx_pkt_dly), .rx_abs_dly(rx_abs_dly),
    .tx_pkt_dly(tx_pkt_dly), .tx_abs_dly(tx_abs_dly), .unit_tick(unit_tick),
    .cancel_all(cancel_all), .rx_cause(rx_cause), .tx_cause(tx_cause),
    .tmr_running(tmr_running)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // kind: 0 = rx event, 1 = tx event with flag, 2 = tx event without flag
  typedef struct packed {
    logic [1:0] kind;
    logic [7:0] pd;
    logic [7:0] ad;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd5,  8'd0},
    '{2'd0, 8'd0,  8'd7},
    '{2'd0, 8'd4,  8'd9},
    '{2'd0, 8'd6,  8'd6},
    '{2'd0, 8'd0,  8'd0},
    '{2'd1, 8'd8,  8'd0},
    '{2'd1, 8'd0,  8'd5},
    '{2'd1, 8'd12, 8'd3},
    '{2'd2, 8'd4,  8'd4},
    '{2'd0, 8'd255, 8'd1}
  };

  task automatic run_vec(input vec_t v, input int idx);
    int first_rx, first_tx, np_rx, np_tx, e_first, e_np;
    bit is_rx;
    is_rx = (v.kind == 2'd0);
    first_rx = -1; first_tx = -1; np_rx = 0; np_tx = 0;
    if (is_rx) begin rx_pkt_dly = v.pd; rx_abs_dly = v.ad; end
    else       begin tx_pkt_dly = v.pd; tx_abs_dly = v.ad; end
    if (is_rx) rx_pkt_done = 1;
    else begin tx_desc_done = 1; tx_desc_ide = (v.kind == 2'd1); end
    cyc();
    rx_pkt_done = 0; tx_desc_done = 0; tx_desc_ide = 0;
    unit_tick = 1;
    for (int k = 0; k <= WIN; k++) begin
      if (k > 0) cyc();
      if (rx_cause) begin np_rx++; if (first_rx < 0) first_rx = k; end
      if (tx_cause) begin np_tx++; if (first_tx < 0) first_tx = k; end
    end
    unit_tick = 0;
    if (is_rx) begin
      if (v.pd == 0 && v.ad == 0) begin e_first = 0; e_np = 1; end
      else begin
        e_first = (v.pd == 0) ? v.ad : (v.ad == 0) ? v.pd : ((v.pd < v.ad) ? v.pd : v.ad);
        e_np = int'(v.pd != 0) + int'(v.ad != 0) - int'(v.pd != 0 && v.pd == v.ad);
      end
      chk(first_rx == e_first, $sformatf("R7 vec%0d rx first", idx), first_rx, e_first);
      chk(np_rx == e_np, $sformatf("R10 vec%0d rx pulses", idx), np_rx, e_np);
      chk(np_tx == 0, $sformatf("R7 vec%0d no tx", idx), np_tx, 0);
    end else begin
      if (v.kind == 2'd2 || v.pd == 0) begin e_first = -1; e_np = 0; end
      else begin
        e_first = (v.ad == 0) ? v.pd : ((v.pd < v.ad) ? v.pd : v.ad);
        e_np = 1 + int'(v.ad != 0 && v.ad != v.pd);
      end
      chk(first_tx == e_first, $sformatf("R6 vec%0d tx first", idx), first_tx, e_first);
      chk(np_tx == e_np, $sformatf("R5 vec%0d tx pulses", idx), np_tx, e_np);
      if (v.kind == 2'd2)
        chk(np_tx == 0, $sformatf("R4 vec%0d no flag", idx), np_tx, 0);
    end
    chk(tmr_running == 4'b0, $sformatf("R7 vec%0d idle", idx), int'(tmr_running), 0);
  endtask

  task automatic ticks(input int n);
    unit_tick = 1;
    for (int i = 0; i < n; i++) cyc();
    unit_tick = 0;
  endtask

  // counts ticks until rx or tx cause, limit 300
  task automatic ticks_to_cause(input bit rx_side, output int n);
    n = -1;
    unit_tick = 1;
    for (int i = 1; i <= 300; i++) begin
      cyc();
      if ((rx_side ? rx_cause : tx_cause) && n < 0) n = i;
    end
    unit_tick = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int n;
    cyc(); cyc(); rst = 0; cyc();
    chk(tmr_running == 0 && !rx_cause && !tx_cause, "R7 reset state", int'(tmr_running), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
    rx_pkt_dly = 0; rx_abs_dly = 0; tx_pkt_dly = 0; tx_abs_dly = 0;

    // R1: packet timer restarts
    rx_pkt_dly = 10; rx_pkt_done = 1; cyc(); rx_pkt_done = 0;
    ticks(6);
    rx_pkt_done = 1; cyc(); rx_pkt_done = 0;
    ticks_to_cause(1'b1, n);
    chk(n == 10, "R1 restart", n, 10);
    rx_pkt_dly = 0;

    // R2: absolute timer holds its count
    rx_abs_dly = 10; rx_pkt_done = 1; cyc(); rx_pkt_done = 0;
    ticks(6);
    rx_pkt_done = 1; cyc(); rx_pkt_done = 0;
    chk(tmr_running == 4'b0010, "R2 abs running", int'(tmr_running), 2);
    ticks_to_cause(1'b1, n);
    chk(n == 4, "R2 hold", n, 4);
    rx_abs_dly = 0;

    // R6/R5: tx absolute continues while packet timer restarts
    tx_pkt_dly = 20; tx_abs_dly = 10; tx_desc_ide = 1;
    tx_desc_done = 1; cyc(); tx_desc_done = 0;
    ticks(6);
    tx_desc_done = 1; cyc(); tx_desc_done = 0;
    chk(tmr_running == 4'b1100, "R5 both tx running", int'(tmr_running), 12);
    // R4: event without flag leaves timers alone
    tx_desc_ide = 0; tx_desc_done = 1; cyc(); tx_desc_done = 0;
    ticks_to_cause(1'b0, n);
    chk(n == 4, "R6 abs first", n, 4);

    // R4: unflagged event on idle transmit side
    tx_pkt_dly = 3; tx_abs_dly = 3; tx_desc_done = 1; cyc(); tx_desc_done = 0;
    chk(tmr_running == 0, "R4 unflagged idle", int'(tmr_running), 0);
    ticks_to_cause(1'b0, n);
    chk(n == -1, "R4 no cause", n, -1);

    // R7: no count without tick
    rx_pkt_dly = 3; rx_pkt_done = 1; cyc(); rx_pkt_done = 0;
    for (int i = 0; i < 20; i++) cyc();
    chk(!rx_cause && tmr_running == 4'b0001, "R7 no tick hold", int'(tmr_running), 1);
    ticks(2);
    chk(!rx_cause, "R7 early", int'(rx_cause), 0);
    // R9: reload on final tick
    unit_tick = 1; rx_pkt_done = 1; cyc(); rx_pkt_done = 0; unit_tick = 0;
    chk(!rx_cause && tmr_running[0], "R9 reload wins", int'(rx_cause), 0);
    ticks_to_cause(1'b1, n);
    chk(n == 3, "R9 restart full", n, 3);

    // R8: cancel
    rx_pkt_dly = 5; rx_abs_dly = 8; tx_pkt_dly = 5; tx_abs_dly = 8;
    rx_pkt_done = 1; tx_desc_done = 1; tx_desc_ide = 1; cyc();
    rx_pkt_done = 0; tx_desc_done = 0; tx_desc_ide = 0;
    chk(tmr_running == 4'b1111, "R8 all armed", int'(tmr_running), 15);
    ticks(2);
    cancel_all = 1; rx_pkt_done = 1; cyc(); cancel_all = 0; rx_pkt_done = 0;
    chk(tmr_running == 0, "R8 cancelled", int'(tmr_running), 0);
    ticks_to_cause(1'b1, n);
    chk(n == -1, "R8 no rx cause", n, -1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule